// File: doc/BRIEF.md
# Codec Command Slot Bridge

This block lets software reach the control registers of an attached audio codec through two transmit slot registers. Software first loads the data slot with the value to write, then writes the command slot. The command slot word holds the codec register address and a direction bit. The command write starts the codec transaction. A write transaction sends a one-cycle write strobe with address and data. A read transaction sends a one-cycle read strobe, then waits for the codec to return a word with a valid pulse.

A read response is stored in two receive slot registers. A flag register shows three things: whether each transmit slot has been consumed, whether a read is still in flight, and whether each receive slot holds unread data. Only one codec read can be outstanding at a time. A command written while a read is in flight is held in a one-deep buffer. It is issued once the response has been accepted. If a second command arrives while one is already held, the newer command replaces the held one.

Serial framing, bit clocks and the audio sample slots belong to other blocks.

Top module: `codec_slot_bridge`

## Requirements
- R1: After reset the flag register (address 4) reads 0x07. Bit 0 (command transmit empty), bit 1 (data transmit empty) and bit 2 (both transmit slots empty) are set. All busy and valid bits (3 to 6) are clear.
- R2: Writing address 1 clears flag bits 1 and 2. Writing address 0 clears flag bits 0 and 2. Once a transaction is issued on the codec interface, bits 0, 1 and 2 are set again.
- R3: A command word whose bit 19 is 0 produces, two clock edges after the bus write, a one-cycle write strobe. The strobe carries the address from command bits 18:12 and the data from data slot bits 19:4.
- R4: A command word whose bit 19 is 1 produces, two clock edges after the bus write, a one-cycle read strobe carrying command bits 18:12. Flag bits 3 and 4 (receive busy) are set from that strobe until the response is accepted.
- R5: When a response is accepted:
  - the command receive slot (address 2) takes the issued command word with bit 19 cleared;
  - the data receive slot (address 3) takes the codec data in bits 19:4, with bits 3:0 zero;
  - flag bits 3 and 4 clear;
  - flag bit 5 (command receive valid) and flag bit 6 (data receive valid) set.
- R6: A bus read of address 2 returns the captured command word and clears flag bit 5. A bus read of address 3 returns the captured data word and clears flag bit 6. Each read leaves the other bit unchanged.
- R7: A command written while a read is outstanding is held. No strobe of any kind appears until the response has been accepted. The held command is issued on a later cycle.
- R8: A codec valid pulse while no read is outstanding is ignored. The receive slots and flag bits 5 and 6 stay unchanged.
- R9: Addresses 0 and 1 read back the low 20 bits of the last word written to them, with upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on receive slots) |
| bus_addr | input | 3 | Register index: 0 cmd tx, 1 data tx, 2 cmd rx, 3 data rx, 4 flags |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| cdc_wr_stb | output | 1 | One-cycle codec register write request |
| cdc_rd_stb | output | 1 | One-cycle codec register read request |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec register write data |
| cdc_rdata | input | 16 | Codec read result |
| cdc_rvalid | input | 1 | Codec read result valid, one cycle |

## Verification
The bench builds the bridge with its default widths: a 20-bit slot, a 7-bit codec address and 16-bit codec data. Its codec model answers reads four cycles after the strobe. That latency leaves a window in which a second command can be written while a read is in flight, which exercises the hold path. It also lets the bench see the busy flags before the response lands. Random reads and writes over the full 128-entry codec address space are checked against a bench-side register image. A stray valid pulse with nothing outstanding is injected to confirm that it is ignored.

// File: rtl/codec_slot_pkg.sv
// Package: shared register indices and flag bit positions for the codec
// command slot bridge. Assumes a word-indexed register bus of 3 address bits.
package codec_slot_pkg;
    typedef logic [2:0] reg_idx_t;

    localparam reg_idx_t RI_CMD_TX = 3'd0;
    localparam reg_idx_t RI_DAT_TX = 3'd1;
    localparam reg_idx_t RI_CMD_RX = 3'd2;
    localparam reg_idx_t RI_DAT_RX = 3'd3;
    localparam reg_idx_t RI_FLAGS  = 3'd4;

    localparam int FLAG_W = 7;
endpackage

// File: rtl/codec_slot_tx.sv
// Transmit slot holding registers with their empty flags.
// Assumes command and data slot writes never coincide (distinct addresses).
module codec_slot_tx #(
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              dat_we,
    input  logic [SLOT_W-1:0] wdata,
    input  logic              issue,
    output logic [SLOT_W-1:0] cmd_q,
    output logic [SLOT_W-1:0] dat_q,
    output logic              cmd_empty,
    output logic              dat_empty
);
    // Capture slot words; a write empties-flag clear wins over an issue set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            dat_q     <= '0;
            cmd_empty <= 1'b1;
            dat_empty <= 1'b1;
        end else begin
            if (cmd_we) cmd_q <= wdata;
            if (dat_we) dat_q <= wdata;
            if (issue) begin
                cmd_empty <= 1'b1;
                dat_empty <= 1'b1;
            end
            if (cmd_we) cmd_empty <= 1'b0;
            if (dat_we) dat_empty <= 1'b0;
        end
    end
endmodule

// File: rtl/codec_slot_issue.sv
// Command hold buffer and codec request sequencer.
// Holds one command (newest wins), issues it when no read is outstanding,
// and tracks the single outstanding read until the codec answers.
module codec_slot_issue #(
    parameter int SLOT_W = 20,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [SLOT_W-1:0] cmd_word,
    input  logic [DATA_W-1:0] dat_field,
    input  logic              rsp_valid,
    output logic              issue,
    output logic              issue_rd,
    output logic              rsp_take,
    output logic [SLOT_W-1:0] inflight_cmd,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam int DIR_BIT = SLOT_W - 1;
    localparam int AF_HI   = SLOT_W - 2;

    logic              hold_vld;
    logic [SLOT_W-1:0] hold_cmd;
    logic [DATA_W-1:0] hold_dat;
    logic              rd_pend;

    // Launch when a command waits and the codec interface is free.
    always_comb begin
        issue    = hold_vld && !rd_pend;
        issue_rd = issue && hold_cmd[DIR_BIT];
        rsp_take = rd_pend && rsp_valid;
    end

    // Sequence strobes, hold buffer and the outstanding-read marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld     <= 1'b0;
            hold_cmd     <= '0;
            hold_dat     <= '0;
            rd_pend      <= 1'b0;
            inflight_cmd <= '0;
            wr_stb       <= 1'b0;
            rd_stb       <= 1'b0;
            addr         <= '0;
            wdata        <= '0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (issue) begin
                hold_vld <= 1'b0;
                addr     <= hold_cmd[AF_HI -: ADDR_W];
                wdata    <= hold_dat;
                if (hold_cmd[DIR_BIT]) begin
                    rd_stb       <= 1'b1;
                    rd_pend      <= 1'b1;
                    inflight_cmd <= hold_cmd;
                end else begin
                    wr_stb <= 1'b1;
                end
            end else if (rsp_take) begin
                rd_pend <= 1'b0;
            end
            if (cmd_we) begin
                hold_vld <= 1'b1;
                hold_cmd <= cmd_word;
                hold_dat <= dat_field;
            end
        end
    end
endmodule

// File: rtl/codec_slot_rx.sv
// Receive slot capture with busy and valid flags.
// Assumes rd_issue and rsp_take never coincide (one read outstanding).
module codec_slot_rx #(
    parameter int SLOT_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic              rsp_take,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [SLOT_W-1:0] inflight_cmd,
    input  logic              clr_cmd_vld,
    input  logic              clr_dat_vld,
    output logic [SLOT_W-1:0] rx_cmd,
    output logic [SLOT_W-1:0] rx_dat,
    output logic              busy,
    output logic              cmd_vld,
    output logic              dat_vld
);
    localparam int PAD_W = SLOT_W - DATA_W;
    localparam logic [SLOT_W-1:0] DIR_MASK = {1'b1, {(SLOT_W-1){1'b0}}};

    // Track busy, capture responses; a capture outranks a read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cmd  <= '0;
            rx_dat  <= '0;
            busy    <= 1'b0;
            cmd_vld <= 1'b0;
            dat_vld <= 1'b0;
        end else begin
            if (rd_issue) busy <= 1'b1;
            if (clr_cmd_vld) cmd_vld <= 1'b0;
            if (clr_dat_vld) dat_vld <= 1'b0;
            if (rsp_take) begin
                busy    <= 1'b0;
                rx_cmd  <= inflight_cmd & ~DIR_MASK;
                rx_dat  <= {rsp_data, {PAD_W{1'b0}}};
                cmd_vld <= 1'b1;
                dat_vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/codec_slot_bridge.sv
// Top: register-mapped bridge from slot registers to a codec request port.
// Decodes bus accesses, wires the transmit, issue and receive stages, and
// forms the read mux. Bus reads are combinational; read side effects occur
// on the clock edge at which bus_rd is high.
module codec_slot_bridge
    import codec_slot_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int SLOT_W = 20,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              cdc_wr_stb,
    output logic              cdc_rd_stb,
    output logic [ADDR_W-1:0] cdc_addr,
    output logic [DATA_W-1:0] cdc_wdata,
    input  logic [DATA_W-1:0] cdc_rdata,
    input  logic              cdc_rvalid
);
    localparam int EXT_W = BUS_W - SLOT_W;

    logic              cmd_we, dat_we, clr_cmd, clr_dat;
    logic [SLOT_W-1:0] slot_wdata;
    logic [SLOT_W-1:0] tx_cmd_q, tx_dat_q, rx_cmd_q, rx_dat_q, inflight;
    logic              cmd_empty, dat_empty;
    logic              issue, issue_rd, rsp_take;
    logic              rx_busy, rx_cmd_vld, rx_dat_vld;
    logic [FLAG_W-1:0] flags;
    logic              unused_hi;

    // Decode register accesses.
    always_comb begin
        cmd_we     = bus_wr && (bus_addr == RI_CMD_TX);
        dat_we     = bus_wr && (bus_addr == RI_DAT_TX);
        clr_cmd    = bus_rd && (bus_addr == RI_CMD_RX);
        clr_dat    = bus_rd && (bus_addr == RI_DAT_RX);
        slot_wdata = bus_wdata[SLOT_W-1:0];
        unused_hi  = ^bus_wdata[BUS_W-1:SLOT_W];
    end

    codec_slot_tx #(.SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .dat_we(dat_we), .wdata(slot_wdata), .issue(issue),
        .cmd_q(tx_cmd_q), .dat_q(tx_dat_q),
        .cmd_empty(cmd_empty), .dat_empty(dat_empty)
    );

    codec_slot_issue #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_iss (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_word(slot_wdata),
        .dat_field(tx_dat_q[SLOT_W-1 -: DATA_W]),
        .rsp_valid(cdc_rvalid),
        .issue(issue), .issue_rd(issue_rd), .rsp_take(rsp_take),
        .inflight_cmd(inflight),
        .wr_stb(cdc_wr_stb), .rd_stb(cdc_rd_stb),
        .addr(cdc_addr), .wdata(cdc_wdata)
    );

    codec_slot_rx #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rd_issue(issue_rd), .rsp_take(rsp_take), .rsp_data(cdc_rdata),
        .inflight_cmd(inflight),
        .clr_cmd_vld(clr_cmd), .clr_dat_vld(clr_dat),
        .rx_cmd(rx_cmd_q), .rx_dat(rx_dat_q),
        .busy(rx_busy), .cmd_vld(rx_cmd_vld), .dat_vld(rx_dat_vld)
    );

    // Assemble the flag word and select read data.
    always_comb begin
        flags = {rx_dat_vld, rx_cmd_vld, rx_busy, rx_busy,
                 cmd_empty && dat_empty, dat_empty, cmd_empty};
        case (bus_addr)
            RI_CMD_TX: bus_rdata = {{EXT_W{1'b0}}, tx_cmd_q};
            RI_DAT_TX: bus_rdata = {{EXT_W{1'b0}}, tx_dat_q};
            RI_CMD_RX: bus_rdata = {{EXT_W{1'b0}}, rx_cmd_q};
            RI_DAT_RX: bus_rdata = {{EXT_W{1'b0}}, rx_dat_q};
            RI_FLAGS:  bus_rdata = {{(BUS_W-FLAG_W){1'b0}}, flags};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/codec_slot_bridge_chk.sv
// Checker: protocol properties of the bridge observed at the codec port
// and at the receive flags. Keeps its own view of the outstanding read.
module codec_slot_bridge_chk #(
    parameter int SLOT_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input logic              cmd_vld,
    input logic              dat_vld,
    input logic [SLOT_W-1:0] rx_dat
);
    localparam int PAD_W = SLOT_W - DATA_W;

    logic ck_out;

    // Independent outstanding-read tracker from port activity.
    always_ff @(posedge clk) begin
        if (!rst_n)      ck_out <= 1'b0;
        else if (rd_stb) ck_out <= 1'b1;
        else if (rvalid) ck_out <= 1'b0;
    end

    a_r7_no_strobe_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ck_out |-> !(wr_stb || rd_stb));

    a_r4_busy_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> busy);

    a_r5_flags_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_out && rvalid) |=> (cmd_vld && dat_vld && !busy));

    a_r5_data_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_out && rvalid) |=> (rx_dat == {$past(rdata), {PAD_W{1'b0}}}));

    a_r8_stray_valid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ck_out && rvalid) |=> $stable(rx_dat));
endmodule

bind codec_slot_bridge codec_slot_bridge_chk #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(cdc_wr_stb), .rd_stb(cdc_rd_stb),
    .rvalid(cdc_rvalid), .rdata(cdc_rdata),
    .busy(rx_busy), .cmd_vld(rx_cmd_vld), .dat_vld(rx_dat_vld),
    .rx_dat(rx_dat_q)
);

// File: tb/tb_codec_slot_bridge.sv
module tb_codec_slot_bridge;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cdc_wr_stb, cdc_rd_stb;
    logic [6:0]  cdc_addr;
    logic [15:0] cdc_wdata;
    logic [15:0] cdc_rdata;
    logic        cdc_rvalid;

    logic        mdl_rvalid = 1'b0;
    logic [15:0] mdl_rdata = '0;
    logic        spur_vld = 1'b0;
    logic [15:0] spur_data = '0;
    logic [15:0] cmem [128];
    logic [15:0] exp_mem [128];
    int          lat_cnt = 0;
    logic [6:0]  lat_addr = '0;
    int          cyc = 0, wr_cyc = 0, rsp_cyc = 0, wr_cnt = 0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    assign cdc_rvalid = mdl_rvalid | spur_vld;
    assign cdc_rdata  = spur_vld ? spur_data : mdl_rdata;

    codec_slot_bridge dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cdc_wr_stb(cdc_wr_stb), .cdc_rd_stb(cdc_rd_stb), .cdc_addr(cdc_addr),
        .cdc_wdata(cdc_wdata), .cdc_rdata(cdc_rdata), .cdc_rvalid(cdc_rvalid)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'(i * 16'h0123) ^ 16'h5A5A;
    endfunction

    function automatic logic [31:0] exp_rx_cmd(logic [31:0] c);
        return c & 32'h0007_FFFF;
    endfunction

    function automatic logic [31:0] exp_rx_dat(logic [15:0] v);
        return {12'h0, v, 4'h0};
    endfunction

    // Codec model with fixed read latency, plus port monitors.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mdl_rvalid <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) cmem[i] <= init_val(i);
            lat_cnt <= 0;
        end else begin
            if (cdc_wr_stb) begin
                cmem[cdc_addr] <= cdc_wdata;
                wr_cyc <= cyc;
                wr_cnt <= wr_cnt + 1;
            end
            if (cdc_rd_stb) begin
                lat_cnt  <= LAT;
                lat_addr <= cdc_addr;
            end else if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    mdl_rvalid <= 1'b1;
                    mdl_rdata  <= cmem[lat_addr];
                end
            end
            if (mdl_rvalid) rsp_cyc <= cyc;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Write command; checks the strobe and flags R2/R3 one edge later.
    task automatic codec_write(logic [6:0] a, logic [15:0] v, bit chk_strobe);
        logic [31:0] f;
        bus_write(3'd1, {12'h0, v, 4'h0});
        bus_write(3'd0, {12'h0, 1'b0, a, 12'h000});
        exp_mem[a] = v;
        if (chk_strobe) begin
            @(negedge clk);
            check("R3 write strobe", {31'h0, cdc_wr_stb}, 32'h1);
            check("R3 write address", {25'h0, cdc_addr}, {25'h0, a});
            check("R3 write data", {16'h0, cdc_wdata}, {16'h0, v});
            bus_read(3'd4, f);
            check("R2 empty flags after issue", f & 32'h7, 32'h7);
        end
    endtask

    task automatic wait_valid(output logic [31:0] f);
        bit got = 0;
        for (int k = 0; k < 40 && !got; k++) begin
            bus_read(3'd4, f);
            if (f[6:5] == 2'b11) got = 1;
        end
    endtask

    task automatic codec_read(logic [6:0] a, logic [11:0] low);
        logic [31:0] c, f, r;
        c = {12'h0, 1'b1, a, low};
        bus_write(3'd0, c);
        @(negedge clk);
        check("R4 read strobe", {31'h0, cdc_rd_stb}, 32'h1);
        check("R4 read address", {25'h0, cdc_addr}, {25'h0, a});
        bus_read(3'd4, f);
        check("R4 busy flags set", f & 32'h18, 32'h18);
        wait_valid(f);
        check("R5 flags after response", f & 32'h78, 32'h60);
        bus_read(3'd2, r);
        check("R6 command rx slot", r, exp_rx_cmd(c));
        bus_read(3'd4, f);
        check("R6 cmd valid cleared, data valid kept", f & 32'h60, 32'h40);
        bus_read(3'd3, r);
        check("R5 data rx slot", r, exp_rx_dat(exp_mem[a]));
        bus_read(3'd4, f);
        check("R6 data valid cleared", f & 32'h60, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] f, r, keep, c;
        int          w0;
        for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(3'd4, f);
        check("R1 reset flags", f, 32'h07);
        bus_read(3'd3, r);
        check("R1 reset data rx slot", r, 32'h0);

        // R2 data write clears data empty and combined
        bus_write(3'd1, 32'hFFFF_FFFF);
        bus_read(3'd4, f);
        check("R2 data write clears bits 1,2", f & 32'h7, 32'h1);
        // R9 readback truncated to 20 bits
        bus_read(3'd1, r);
        check("R9 data slot readback", r, 32'h000F_FFFF);

        // R2 cmd write clears bit 0 before issue, all set after
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h0003_5000;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b1; bus_addr = 3'd4;
        #1 check("R2 cmd write clears bit 0", bus_rdata & 32'h7, 32'h0);
        @(negedge clk);
        bus_rd = 1'b0;
        exp_mem[7'h35] = 16'hFFFF;
        bus_read(3'd0, r);
        check("R9 command slot readback", r, 32'h0003_5000);
        bus_read(3'd4, f);
        check("R2 flags set after issue", f & 32'h7, 32'h7);

        // Directed writes and reads at address extremes
        codec_write(7'h00, 16'h1234, 1);
        codec_write(7'h7F, 16'hFFFF, 1);
        codec_read(7'h00, 12'hABC);
        codec_read(7'h7F, 12'h000);
        codec_read(7'h35, 12'hFFF);

        // R7 command written while a read is outstanding is held
        c = {12'h0, 1'b1, 7'h11, 12'h055};
        bus_write(3'd0, c);
        w0 = wr_cnt;
        codec_write(7'h22, 16'hC0DE, 0);
        wait_valid(f);
        for (int k = 0; k < 20 && wr_cnt == w0; k++) @(negedge clk);
        check("R7 held write issued once", wr_cnt - w0, 1);
        check("R7 held write after response", {31'h0, wr_cyc > rsp_cyc}, 32'h1);
        bus_read(3'd2, r);
        check("R7 read result of first command", r, exp_rx_cmd(c));
        bus_read(3'd3, r);
        check("R7 read data of first command", r, exp_rx_dat(exp_mem[7'h11]));
        keep = r;
        codec_read(7'h22, 12'h001);

        // R8 stray response with nothing outstanding
        bus_read(3'd3, keep);
        @(negedge clk);
        spur_vld = 1'b1; spur_data = 16'hBEEF;
        @(negedge clk);
        spur_vld = 1'b0;
        bus_read(3'd4, f);
        check("R8 valid flags untouched", f & 32'h78, 32'h0);
        bus_read(3'd3, r);
        check("R8 data rx slot unchanged", r, keep);

        // Constrained random mix
        for (int n = 0; n < 40; n++) begin
            logic [6:0]  ra;
            logic [15:0] rv;
            ra = 7'($urandom % 128);
            rv = 16'($urandom);
            if ($urandom % 2 == 0) codec_write(ra, rv, 1);
            else codec_read(ra, 12'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule